// File: doc/BRIEF.md
# Paired-Channel Edge Interval Capture

This block is a timer input-capture unit. It joins two capture channels so that they measure the time between two edges of one input signal. A free-running 16-bit counter is the timebase. The input passes through a two-flop synchroniser, and its edges are detected on the synchronised value. The first channel latches the counter on the edge its select field asks for. The second channel latches the counter on the next edge its own select field asks for. Software controls the unit through a small register port: it writes the control bits, clears the flags by writing 1, and reads the captured values.

The pair of capture registers is read coherently. Reading the first capture value copies the current second capture value into a shadow. The next read of the second capture value returns that shadow, even if a newer measurement has overwritten the live register in between. In continuous mode the arm bit stays set, so measurements repeat. In single mode the hardware clears the arm bit once a pair completes.

Top module: `dec_pair`

Register map (3-bit address): 0 = control, 1 = flags, 2 = first capture, 3 = second capture, 4 = counter.
Control bits: [0] mode enable, [1] arm, [2] continuous, [3] spare (stored and read back), [5:4] first-channel edge select, [7:6] second-channel edge select.
Flags: [0] first-channel flag, [1] second-channel flag.

## Requirements
- R1: After reset, the control and flag registers and both capture registers read 0.
- R2: The counter (address 4) rises by one every clock cycle.
- R3: With mode enable and arm both 1, and no measurement in progress, a matching edge sets flag bit 0 and stores the counter into the first capture. When the input changes just after a clock edge at which the counter reads C, the stored value is C+2.
- R4: The second capture (flag bit 1) is taken only on a matching edge that comes after the first capture of the same measurement. It stores the counter with the same +2 latency, and a completed pair ends the measurement.
- R5: Edge-select codes: 00 = no capture, 01 = rising edge, 10 = falling edge, 11 = either edge. An edge that does not match the select code leaves the flags and the capture registers unchanged.
- R6: No capture takes place unless both mode enable and arm are 1.
- R7: In single mode (continuous = 0), a completed pair clears the arm bit and no further captures occur. In continuous mode the arm bit stays 1.
- R8: Writing 1 to a flag bit clears that flag. If a capture and a clear of the same flag happen in the same cycle, the flag ends up set.
- R9: After the first capture is read, a read of the second capture returns the value the second capture held at the time of that first read, even if a later pair has since been captured.
- R10: A read of the second capture with no shadow pending returns the live second capture. Each read of the second capture clears the pending shadow.
- R11: In continuous mode, each new first edge after a completed pair starts a new measurement and overwrites the captures, whether or not the previous pair was read.
- R12: Clearing mode enable (or arm) while a measurement is in progress abandons it. The next matching edge is then treated as a first edge, and the second capture is left untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sig_in | input | 1 | Asynchronous input being measured |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe; its side effects take effect at the clock edge |
| rd_addr | input | 3 | Read address |
| rd_data | output | 16 | Read data, combinational from rd_addr |

## Verification
The bench targets the following cases, and what a faulty design would do in each:
- A flag clear that lands in the same cycle as a capture. A design that gives the clear priority would lose the new flag.
- An edge that arrives before a first capture has happened. A design without first/second sequencing would fill the second capture early, or fill both captures from one edge.
- A new pair captured between the read of the first value and the read of the second. A design without the shadow would hand back a mixed pair; a design whose shadow never expires would keep returning stale data.
- Abandoning a measurement partway, and the end of a pair in single mode. A design that keeps its "waiting for second edge" state would wrongly fill the second capture, and a single-mode design that leaves arm set would keep capturing.

// File: rtl/dec_pkg.sv
// Package: shared types for the paired-channel edge capture block.
// Assumes an 8-bit control register and a 3-bit register address.
package dec_pkg;

    typedef enum logic [2:0] {
        RA_CTRL  = 3'd0,
        RA_FLAGS = 3'd1,
        RA_CAPA  = 3'd2,
        RA_CAPB  = 3'd3,
        RA_CNT   = 3'd4
    } reg_addr_e;

    typedef enum logic [1:0] {
        ES_OFF  = 2'b00,
        ES_RISE = 2'b01,
        ES_FALL = 2'b10,
        ES_BOTH = 2'b11
    } edge_sel_e;

    typedef struct packed {
        logic [1:0] sel_b;
        logic [1:0] sel_a;
        logic       spare;
        logic       cont;
        logic       arm;
        logic       en;
    } ctrl_t;

    // Returns 1 when the detected edge matches the select code.
    function automatic logic sel_match(input logic [1:0] sel, input logic rise, input logic fall);
        case (sel)
            ES_RISE: return rise;
            ES_FALL: return fall;
            ES_BOTH: return rise | fall;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/dec_sync_edge.sv
// Synchroniser and edge detector.
// Passes the asynchronous input through STAGES flops, then flags a
// one-cycle rise or fall pulse on the synchronised value.
// Assumes STAGES >= 2.
module dec_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              last_q;

    // First synchroniser stage samples the raw input.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= async_in;
    end

    genvar gi;
    generate
        for (gi = 1; gi < STAGES; gi++) begin : g_stage
            // Each later stage copies the one before it.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[gi] <= 1'b0;
                else        chain[gi] <= chain[gi-1];
            end
        end
    endgenerate

    // Hold the previous synchronised value for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= chain[STAGES-1];
    end

    assign rise =  chain[STAGES-1] & ~last_q;
    assign fall = ~chain[STAGES-1] &  last_q;
endmodule

// File: rtl/dec_counter.sv
// Free-running timebase counter. It wraps modulo 2**W and has no enable.
module dec_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] count
);
    // Advance by one each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else        count <= count + 1'b1;
    end
endmodule

// File: rtl/dec_capture.sv
// Capture sequencer for the channel pair.
// A first-channel match while idle stores the counter into cap_a and
// starts a measurement. A second-channel match during a measurement
// stores cap_b and ends it. Losing enable or arm drops the measurement.
// In single mode, arm_clr pulses when a pair completes.
module dec_capture #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mode_en,
    input  logic         arm,
    input  logic         cont,
    input  logic [1:0]   sel_a,
    input  logic [1:0]   sel_b,
    input  logic         rise,
    input  logic         fall,
    input  logic [W-1:0] count,
    output logic         hit_a,
    output logic         hit_b,
    output logic         waiting,
    output logic         arm_clr,
    output logic [W-1:0] cap_a,
    output logic [W-1:0] cap_b
);
    import dec_pkg::*;

    logic active;

    // Decide which channel, if either, captures this cycle.
    always_comb begin
        active  = mode_en & arm;
        hit_a   = active & ~waiting & sel_match(sel_a, rise, fall);
        hit_b   = active &  waiting & sel_match(sel_b, rise, fall);
        arm_clr = hit_b & ~cont;
    end

    // Step the measurement state and latch the counter into the captures.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            waiting <= 1'b0;
            cap_a   <= '0;
            cap_b   <= '0;
        end else if (!active) begin
            waiting <= 1'b0;
        end else if (hit_a) begin
            cap_a   <= count;
            waiting <= 1'b1;
        end else if (hit_b) begin
            cap_b   <= count;
            waiting <= 1'b0;
        end
    end
endmodule

// File: rtl/dec_coherent_rd.sv
// Read path with pair coherency.
// Reading the first capture copies the second capture into a shadow and
// marks it pending. A read of the second capture returns the shadow while
// it is pending, and clears the pending mark. rd_data is combinational.
module dec_coherent_rd #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rd_en,
    input  logic [2:0]   rd_addr,
    input  logic [7:0]   ctrl,
    input  logic [1:0]   flags,
    input  logic [W-1:0] cap_a,
    input  logic [W-1:0] cap_b,
    input  logic [W-1:0] count,
    output logic [W-1:0] rd_data,
    output logic [W-1:0] shadow,
    output logic         pend
);
    import dec_pkg::*;

    // Take a snapshot on a first-capture read; release it on a second-capture read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow <= '0;
            pend   <= 1'b0;
        end else if (rd_en && rd_addr == RA_CAPA) begin
            shadow <= cap_b;
            pend   <= 1'b1;
        end else if (rd_en && rd_addr == RA_CAPB) begin
            pend   <= 1'b0;
        end
    end

    // Select the register named by the read address.
    always_comb begin
        case (rd_addr)
            RA_CTRL:  rd_data = {{(W-8){1'b0}}, ctrl};
            RA_FLAGS: rd_data = {{(W-2){1'b0}}, flags};
            RA_CAPA:  rd_data = cap_a;
            RA_CAPB:  rd_data = pend ? shadow : cap_b;
            RA_CNT:   rd_data = count;
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/dec_pair.sv
// Top level: paired-channel edge interval capture.
// Holds the control and flag registers and connects the synchroniser,
// the counter, the capture sequencer and the coherent read path.
// Assumes CNT_W >= 8 and SYNC_STAGES >= 2.
module dec_pair #(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sig_in,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [7:0]       wr_data,
    input  logic             rd_en,
    input  logic [2:0]       rd_addr,
    output logic [CNT_W-1:0] rd_data
);
    import dec_pkg::*;

    ctrl_t            ctrl_q;
    logic [1:0]       flags_q;
    logic             rise, fall;
    logic [CNT_W-1:0] count, cap_a, cap_b, shadow;
    logic             hit_a, hit_b, waiting, arm_clr, pend;
    logic             mode_en, arm_bit, cont_bit;
    logic             wr_ctrl, wr_flags;

    assign mode_en  = ctrl_q.en;
    assign arm_bit  = ctrl_q.arm;
    assign cont_bit = ctrl_q.cont;
    assign wr_ctrl  = wr_en && wr_addr == RA_CTRL;
    assign wr_flags = wr_en && wr_addr == RA_FLAGS;

    dec_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(sig_in), .rise(rise), .fall(fall)
    );

    dec_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .count(count)
    );

    dec_capture #(.W(CNT_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .mode_en(mode_en), .arm(arm_bit),
        .cont(cont_bit), .sel_a(ctrl_q.sel_a), .sel_b(ctrl_q.sel_b),
        .rise(rise), .fall(fall), .count(count), .hit_a(hit_a),
        .hit_b(hit_b), .waiting(waiting), .arm_clr(arm_clr),
        .cap_a(cap_a), .cap_b(cap_b)
    );

    dec_coherent_rd #(.W(CNT_W)) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
        .ctrl(ctrl_q), .flags(flags_q), .cap_a(cap_a), .cap_b(cap_b),
        .count(count), .rd_data(rd_data), .shadow(shadow), .pend(pend)
    );

    // Control register: a software write wins; otherwise a completed single pair disarms.
    always_ff @(posedge clk) begin
        if (!rst_n)        ctrl_q <= '0;
        else if (wr_ctrl)  ctrl_q <= ctrl_t'(wr_data);
        else if (arm_clr)  ctrl_q.arm <= 1'b0;
    end

    // Flags: write 1 to clear; a capture in the same cycle sets the flag regardless.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= 2'b00;
        end else begin
            flags_q[0] <= hit_a | (flags_q[0] & ~(wr_flags & wr_data[0]));
            flags_q[1] <= hit_b | (flags_q[1] & ~(wr_flags & wr_data[1]));
        end
    end
endmodule

// File: rtl/dec_pair_chk.sv
// Checker for dec_pair: temporal properties across its sub-blocks.
// Attached to every dec_pair instance through the bind below.
module dec_pair_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] cap_a,
    input logic [CNT_W-1:0] cap_b,
    input logic [CNT_W-1:0] shadow,
    input logic             pend,
    input logic             hit_a,
    input logic             hit_b,
    input logic             waiting,
    input logic             mode_en,
    input logic             arm_bit,
    input logic             cont_bit,
    input logic [1:0]       flags_q,
    input logic             rd_en,
    input logic [2:0]       rd_addr,
    input logic             wr_en,
    input logic [2:0]       wr_addr
);
    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (count == CNT_W'($past(count) + 1'b1)));

    assert_second_after_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cap_b) |-> $past(waiting));

    assert_idle_when_unarmed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(mode_en && arm_bit) |=> ($stable(cap_a) && $stable(cap_b)));

    assert_single_disarm_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_b && !cont_bit && !(wr_en && wr_addr == 3'd0)) |=> !arm_bit);

    assert_set_wins_a_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hit_a |=> flags_q[0]);

    assert_set_wins_b_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hit_b |=> flags_q[1]);

    assert_shadow_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !(rd_en && rd_addr == 3'd2)) |=> $stable(shadow));
endmodule

bind dec_pair dec_pair_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .count(count), .cap_a(cap_a), .cap_b(cap_b),
    .shadow(shadow), .pend(pend), .hit_a(hit_a), .hit_b(hit_b),
    .waiting(waiting), .mode_en(mode_en), .arm_bit(arm_bit),
    .cont_bit(cont_bit), .flags_q(flags_q), .rd_en(rd_en),
    .rd_addr(rd_addr), .wr_en(wr_en), .wr_addr(wr_addr)
);

// File: tb/dec_pair_tb.sv
`timescale 1ns/1ps
// Directed bench for dec_pair: one task per scenario, each checking its own results.
module dec_pair_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sig_in = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        rd_en = 1'b0;
    logic [2:0]  rd_addr = '0;
    logic [15:0] rd_data;

    int n_chk  = 0;
    int n_fail = 0;

    localparam logic [2:0] A_CTRL = 3'd0, A_FLG = 3'd1, A_CA = 3'd2, A_CB = 3'd3, A_CNT = 3'd4;

    always #2.5 clk = ~clk;

    dec_pair u_dut (
        .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        #0.5 wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int d);
        @(negedge clk);
        rd_addr = a; rd_en = 1'b1;
        #0.5 d = int'(rd_data);
        @(posedge clk);
        #0.5 rd_en = 1'b0;
    endtask

    // Change the input just after a clock edge; return the counter value at that time.
    task automatic drive(input logic v, output int c);
        @(negedge clk);
        rd_addr = A_CNT;
        #0.5 c = int'(rd_data);
        sig_in = v;
    endtask

    task automatic settle();
        repeat (4) @(posedge clk);
    endtask

    function automatic int plus2(input int c);
        return (c + 2) & 16'hFFFF;
    endfunction

    task automatic t_reset();
        int d;
        rd(A_CTRL, d); chk("R1", "ctrl after reset", d, 0);
        rd(A_FLG, d);  chk("R1", "flags after reset", d, 0);
        rd(A_CB, d);   chk("R1", "second capture after reset", d, 0);
        rd(A_CA, d);   chk("R1", "first capture after reset", d, 0);
        rd(A_CB, d);   // release the shadow taken by the read above
    endtask

    task automatic t_counter();
        int c0, c1;
        @(negedge clk); rd_addr = A_CNT; #0.5 c0 = int'(rd_data);
        repeat (7) @(negedge clk);
        #0.5 c1 = int'(rd_data);
        chk("R2", "counter advance over 7 cycles", c1, (c0 + 7) & 16'hFFFF);
    endtask

    task automatic t_period();
        int c1, c2, x, d;
        wr(A_CTRL, 8'h57);                       // rise/rise, continuous, armed, enabled
        drive(1'b1, c1); settle();
        rd(A_FLG, d); chk("R3", "first flag after first rise", d, 1);
        drive(1'b0, x); settle();
        rd(A_FLG, d); chk("R5", "falling edge ignored by rising select", d, 1);
        drive(1'b1, c2); settle();
        rd(A_FLG, d); chk("R4", "both flags after second rise", d, 3);
        rd(A_CA, d);  chk("R3", "first capture value", d, plus2(c1));
        rd(A_CB, d);  chk("R4", "second capture value", d, plus2(c2));
        rd(A_CTRL, d); chk("R7", "continuous mode keeps arm", d, 8'h57);
        wr(A_FLG, 8'h03);
        rd(A_FLG, d); chk("R8", "write-one clears both flags", d, 0);
    endtask

    task automatic t_edge_sel();
        int c1, c2, x, d;
        drive(1'b0, x); settle();                // input low; falling edge unmatched
        wr(A_CTRL, 8'hE7);                       // first = falling, second = either
        wr(A_FLG, 8'h03);
        drive(1'b1, x); settle();
        rd(A_FLG, d); chk("R5", "rising edge ignored by falling select", d, 0);
        drive(1'b0, c1); settle();
        drive(1'b1, c2); settle();
        rd(A_FLG, d); chk("R5", "falling then either-edge pair", d, 3);
        rd(A_CA, d);  chk("R5", "falling-edge capture", d, plus2(c1));
        rd(A_CB, d);  chk("R5", "either-edge capture", d, plus2(c2));
        wr(A_CTRL, 8'h07);                       // both selects off
        wr(A_FLG, 8'h03);
        drive(1'b0, x); settle();
        drive(1'b1, x); settle();
        rd(A_FLG, d); chk("R5", "select code 00 captures nothing", d, 0);
        rd(A_CA, d);  chk("R5", "first capture kept with select 00", d, plus2(c1));
        rd(A_CB, d);
    endtask

    task automatic t_disabled();
        int x, d, keep;
        rd(A_CA, keep); rd(A_CB, x);
        wr(A_CTRL, 8'h55);                       // enabled, not armed
        drive(1'b0, x); settle(); drive(1'b1, x); settle();
        rd(A_FLG, d); chk("R6", "no capture while unarmed", d, 0);
        wr(A_CTRL, 8'h56);                       // armed, not enabled
        drive(1'b0, x); settle(); drive(1'b1, x); settle();
        rd(A_FLG, d); chk("R6", "no capture while disabled", d, 0);
        rd(A_CA, d);  chk("R6", "first capture unchanged", d, keep);
        rd(A_CB, x);
    endtask

    task automatic t_single();
        int c1, c2, x, d;
        wr(A_CTRL, 8'h53);                       // single mode
        drive(1'b0, x); settle();
        drive(1'b1, c1); settle();
        drive(1'b0, x); settle();
        drive(1'b1, c2); settle();
        rd(A_FLG, d);  chk("R7", "single-mode pair flags", d, 3);
        rd(A_CTRL, d); chk("R7", "arm cleared after single pair", d, 8'h51);
        wr(A_FLG, 8'h03);
        drive(1'b0, x); settle(); drive(1'b1, x); settle();
        rd(A_FLG, d);  chk("R7", "no capture after disarm", d, 0);
        rd(A_CA, d);   chk("R7", "first capture kept after disarm", d, plus2(c1));
        rd(A_CB, d);   chk("R7", "second capture kept after disarm", d, plus2(c2));
    endtask

    task automatic t_set_wins();
        int c, x, d;
        wr(A_CTRL, 8'h57);
        wr(A_FLG, 8'h03);
        drive(1'b0, x); settle();
        drive(1'b1, c);
        repeat (2) @(posedge clk);
        wr(A_FLG, 8'h01);                        // clear lands on the capture cycle
        rd(A_FLG, d); chk("R8", "set wins over same-cycle clear", d, 1);
        wr(A_FLG, 8'h01);
        rd(A_FLG, d); chk("R8", "plain clear of first flag", d, 0);
        drive(1'b0, x); settle();
        drive(1'b1, x); settle();
        rd(A_FLG, d); chk("R4", "second flag only after first capture", d, 2);
    endtask

    task automatic t_coherent();
        int a1, b1, c3, c4, x, d;
        rd(A_CA, a1);                            // shadow takes the current second capture
        wr(A_FLG, 8'h03);
        drive(1'b0, x); settle();
        drive(1'b1, c3); settle();
        drive(1'b0, x); settle();
        drive(1'b1, c4); settle();
        rd(A_CB, d); b1 = d;
        rd(A_CB, d); chk("R10", "live second capture after shadow released", d, plus2(c4));
        chk("R9", "shadow differs from live value", (b1 != d) ? 1 : 0, 1);
        rd(A_CA, d); chk("R11", "first capture overwritten by new pair", d, plus2(c3));
        chk("R11", "overwritten value differs", (d != a1) ? 1 : 0, 1);
        rd(A_CB, d); chk("R9", "coherent second value after first read", d, plus2(c4));
    endtask

    task automatic t_stale_pair();
        int old_b, x, d;
        rd(A_CB, old_b);
        rd(A_CA, x);                             // snapshot old second value
        drive(1'b0, x); settle(); drive(1'b1, x); settle();
        drive(1'b0, x); settle(); drive(1'b1, x); settle();
        rd(A_CB, d); chk("R9", "second read returns pre-capture snapshot", d, old_b);
    endtask

    task automatic t_abandon();
        int c5, c6, x, d, b;
        rd(A_CB, b);
        wr(A_FLG, 8'h03);
        drive(1'b0, x); settle();
        drive(1'b1, c5); settle();               // first capture, measurement open
        wr(A_CTRL, 8'h56);                       // drop enable
        wr(A_CTRL, 8'h57);
        drive(1'b0, x); settle();
        drive(1'b1, c6); settle();
        rd(A_FLG, d); chk("R12", "abandoned measurement restarts as first", d, 1);
        rd(A_CA, d);  chk("R12", "first capture retaken", d, plus2(c6));
        rd(A_CB, d);  chk("R12", "second capture untouched", d, b);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #0.5 rst_n = 1'b1;
        t_reset();
        t_counter();
        t_period();
        t_edge_sel();
        t_disabled();
        t_single();
        t_set_wins();
        t_coherent();
        t_stale_pair();
        t_abandon();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #500000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule